// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Shortcut Flags

The block gathers level-sensitive interrupt requests from three groups of inputs. The first is a basic group of 8 lines. The other two are general groups of 32 lines each. Every general group has its own enable mask, a pending view and a set-and-clear pair of write ports. A summary register presents three things: the basic lines, one cascade flag per general group, and a set of shortcut bits. Each shortcut bit flags one chosen general line directly. An interrupt service routine can usually find the active line from the summary register alone, and it needs to read a group's pending register only when that group's cascade flag is up.

The block drives one IRQ output, which is the OR of all summary bits. It also drives one FIQ output, which follows a single raw line picked by a control register. Software reaches the block through a plain 32-bit register bus. Reads are combinational. A write takes effect at the clock edge on which the write strobe is high. Each source input is sampled into a register on every clock.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable mask and the FIQ control register are zero, every pending and enable read returns 0, and irq_o and fiq_o are low.
- R2: A write to an enable offset (0x10 general group A, 0x14 general group B, 0x18 basic group) sets each enable bit whose data bit is 1 and leaves the others unchanged. Reading the same offset returns the group's enable mask.
- R3: A write to a disable offset (0x1C group A, 0x20 group B, 0x24 basic group) clears each enable bit whose data bit is 1 and leaves the others unchanged. Reading a disable offset returns the group's enable mask.
- R4: The pending registers of the general groups (0x04 for A, 0x08 for B) show the sampled source level ANDed with the enable mask. The source is sampled one clock before it appears. These registers are read-only, so writes to them change nothing.
- R5: Bits 7:0 of the summary register at 0x00 show the sampled basic lines ANDed with the basic enable mask.
- R6: Summary bit 8 (group A) or bit 9 (group B) is 1 when that group has an enabled, active line that has no shortcut. No enable exists for bits 8 and 9, so writes to the basic disable offset leave them unchanged.
- R7: Summary bits 10..14 flag group A lines 7, 9, 10, 18 and 19, in that order. Bits 15..20 flag group B lines 21, 22, 23, 24, 25 and 30, in that order. A shortcut line that is enabled and active sets its shortcut bit and its own group pending bit, but it never sets the cascade flag. Summary bits 31..21 read 0.
- R8: The basic enable mask has only 8 bits. Data bits 8 and above written to 0x18 or 0x24 have no effect, and this includes the shortcut positions.
- R9: irq_o is high exactly when some bit of the summary register is 1.
- R10: The FIQ control register at 0x0C holds a source index in bits 6:0 and an FIQ enable in bit 7. Bits 31..8 read 0. The index counts group A lines 0..31 first, then group B lines as 32..63, then basic lines as 64..71. An index of 72 or more selects nothing.
- R11: fiq_o is the selected raw sampled line ANDed with the FIQ enable. The IRQ enable masks do not affect it.
- R12: A read from any offset outside the map returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_basic | input | 8 | Basic group level inputs |
| src_gen_a | input | 32 | General group A level inputs |
| src_gen_b | input | 32 | General group B level inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Some checks run on every clock. These cover the set and clear semantics of each enable mask, and that a mask stays stable when no write targets it. They also cover that irq_o cannot rise while all masks are zero, that fiq_o stays low while the FIQ enable is off, and that a group whose active lines are all shortcut lines never raises its cascade flag. Other behaviour needs the bench's scenarios. This includes the exact bit position of each shortcut, the ordering of the linear FIQ index, the read-only pending offsets, the inert upper bits of the basic enable, and the zero reads from unmapped offsets.

// File: rtl/bic_pkg.sv
package bic_pkg;

    localparam int unsigned BUS_W    = 32;
    localparam int unsigned ADDR_W   = 6;
    localparam int unsigned BASIC_N  = 8;
    localparam int unsigned GEN_N    = 32;
    localparam int unsigned SC_A_N   = 5;
    localparam int unsigned SC_B_N   = 6;

    // summary register layout
    localparam int unsigned SUM_CASC_A = BASIC_N;
    localparam int unsigned SUM_CASC_B = BASIC_N + 1;
    localparam int unsigned SUM_SC_A   = BASIC_N + 2;
    localparam int unsigned SUM_SC_B   = SUM_SC_A + SC_A_N;
    localparam int unsigned SUM_W      = SUM_SC_B + SC_B_N;

    // shortcut source lists, in summary-bit order
    localparam int SC_A_SRC [SC_A_N] = '{7, 9, 10, 18, 19};
    localparam int SC_B_SRC [SC_B_N] = '{21, 22, 23, 24, 25, 30};

    // linear FIQ index space: group A, group B, then basic
    localparam int unsigned FIQ_SEL_W = 7;
    localparam int unsigned FIQ_TOTAL = 2 * GEN_N + BASIC_N;

    // register offsets
    localparam logic [ADDR_W-1:0] OFF_SUMMARY = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND_A  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_PEND_B  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_FIQ     = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_SET_A   = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_SET_B   = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_SET_0   = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_CLR_A   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_CLR_B   = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_CLR_0   = 6'h24;

    typedef struct packed {
        logic                 en;
        logic [FIQ_SEL_W-1:0] sel;
    } fiq_ctrl_t;

    localparam int unsigned FIQ_CTRL_W = $bits(fiq_ctrl_t);

    function automatic logic [GEN_N-1:0] sc_mask_a();
        logic [GEN_N-1:0] m;
        m = '0;
        for (int i = 0; i < int'(SC_A_N); i++) m[SC_A_SRC[i]] = 1'b1;
        return m;
    endfunction

    function automatic logic [GEN_N-1:0] sc_mask_b();
        logic [GEN_N-1:0] m;
        m = '0;
        for (int i = 0; i < int'(SC_B_N); i++) m[SC_B_SRC[i]] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/bic_bank.sv
module bic_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] wbits,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] en_q,
    output logic [WIDTH-1:0] lvl_q,
    output logic [WIDTH-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            lvl_q <= '0;
        end else begin
            lvl_q <= src;
            if (set_we)      en_q <= en_q | wbits;
            else if (clr_we) en_q <= en_q & ~wbits;
        end
    end

    assign pend = lvl_q & en_q;

    // R2: ones written to the enable port end up set
    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((en_q & $past(wbits)) == $past(wbits)));

    // R3: ones written to the disable port end up clear
    assert_clr_sticks_R3: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((en_q & $past(wbits)) == '0));

    // R2: without a write the mask holds
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(en_q));

endmodule

// File: rtl/bic_summary.sv
module bic_summary
    import bic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BASIC_N-1:0] pend0,
    input  logic [GEN_N-1:0] pend_a,
    input  logic [GEN_N-1:0] pend_b,
    output logic [SUM_W-1:0] sum,
    output logic             irq
);

    localparam logic [GEN_N-1:0] MASK_A = sc_mask_a();
    localparam logic [GEN_N-1:0] MASK_B = sc_mask_b();

    always_comb begin
        sum = '0;
        sum[BASIC_N-1:0] = pend0;
        sum[SUM_CASC_A]  = |(pend_a & ~MASK_A);
        sum[SUM_CASC_B]  = |(pend_b & ~MASK_B);
        for (int i = 0; i < int'(SC_A_N); i++) sum[SUM_SC_A + i] = pend_a[SC_A_SRC[i]];
        for (int i = 0; i < int'(SC_B_N); i++) sum[SUM_SC_B + i] = pend_b[SC_B_SRC[i]];
    end

    assign irq = |sum;

    // R7: a group with only shortcut lines active never raises its cascade flag
    assert_sc_no_casc_a_R7: assert property (@(posedge clk) disable iff (rst)
        ((pend_a & ~MASK_A) == '0) |-> !sum[SUM_CASC_A]);
    assert_sc_no_casc_b_R7: assert property (@(posedge clk) disable iff (rst)
        ((pend_b & ~MASK_B) == '0) |-> !sum[SUM_CASC_B]);

endmodule

// File: rtl/bic_fiq_sel.sv
module bic_fiq_sel
    import bic_pkg::*;
(
    input  fiq_ctrl_t          ctrl,
    input  logic [GEN_N-1:0]   lvl_a,
    input  logic [GEN_N-1:0]   lvl_b,
    input  logic [BASIC_N-1:0] lvl_0,
    output logic               fiq
);

    logic [FIQ_TOTAL-1:0] flat;
    logic                 pick;

    assign flat = {lvl_0, lvl_b, lvl_a};

    always_comb begin
        pick = 1'b0;
        if (int'(ctrl.sel) < int'(FIQ_TOTAL)) pick = flat[ctrl.sel];
    end

    assign fiq = ctrl.en & pick;

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import bic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wen,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [BASIC_N-1:0] src_basic,
    input  logic [GEN_N-1:0]   src_gen_a,
    input  logic [GEN_N-1:0]   src_gen_b,
    output logic               irq_o,
    output logic               fiq_o
);

    logic [BASIC_N-1:0] en0, lvl0, pend0;
    logic [GEN_N-1:0]   en_a, lvl_a, pend_a;
    logic [GEN_N-1:0]   en_b, lvl_b, pend_b;
    logic [SUM_W-1:0]   sum;
    fiq_ctrl_t          fiq_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] off);
        return bus_wen && (a == off);
    endfunction

    bic_bank #(.WIDTH(BASIC_N)) u_bank0 (
        .clk(clk), .rst(rst),
        .set_we(hit(bus_addr, OFF_SET_0)), .clr_we(hit(bus_addr, OFF_CLR_0)),
        .wbits(bus_wdata[BASIC_N-1:0]), .src(src_basic),
        .en_q(en0), .lvl_q(lvl0), .pend(pend0)
    );

    bic_bank #(.WIDTH(GEN_N)) u_bank_a (
        .clk(clk), .rst(rst),
        .set_we(hit(bus_addr, OFF_SET_A)), .clr_we(hit(bus_addr, OFF_CLR_A)),
        .wbits(bus_wdata[GEN_N-1:0]), .src(src_gen_a),
        .en_q(en_a), .lvl_q(lvl_a), .pend(pend_a)
    );

    bic_bank #(.WIDTH(GEN_N)) u_bank_b (
        .clk(clk), .rst(rst),
        .set_we(hit(bus_addr, OFF_SET_B)), .clr_we(hit(bus_addr, OFF_CLR_B)),
        .wbits(bus_wdata[GEN_N-1:0]), .src(src_gen_b),
        .en_q(en_b), .lvl_q(lvl_b), .pend(pend_b)
    );

    bic_summary u_sum (
        .clk(clk), .rst(rst),
        .pend0(pend0), .pend_a(pend_a), .pend_b(pend_b),
        .sum(sum), .irq(irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst)                          fiq_q <= '0;
        else if (hit(bus_addr, OFF_FIQ))  fiq_q <= fiq_ctrl_t'(bus_wdata[FIQ_CTRL_W-1:0]);
    end

    bic_fiq_sel u_fiq (
        .ctrl(fiq_q), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_0(lvl0), .fiq(fiq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_SUMMARY:            bus_rdata[SUM_W-1:0]      = sum;
            OFF_PEND_A:             bus_rdata[GEN_N-1:0]      = pend_a;
            OFF_PEND_B:             bus_rdata[GEN_N-1:0]      = pend_b;
            OFF_FIQ:                bus_rdata[FIQ_CTRL_W-1:0] = fiq_q;
            OFF_SET_A, OFF_CLR_A:   bus_rdata[GEN_N-1:0]      = en_a;
            OFF_SET_B, OFF_CLR_B:   bus_rdata[GEN_N-1:0]      = en_b;
            OFF_SET_0, OFF_CLR_0:   bus_rdata[BASIC_N-1:0]    = en0;
            default:                bus_rdata = '0;
        endcase
    end

    // R9: no request can leave while every mask is empty
    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((en0 != '0) || (en_a != '0) || (en_b != '0)));

    // R11: FIQ output silent while its enable is off
    assert_fiq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        !fiq_q.en |-> !fiq_o);

endmodule

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  bus_addr;
    logic        bus_wen;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  src_basic;
    logic [31:0] src_gen_a;
    logic [31:0] src_gen_b;
    logic        irq_o;
    logic        fiq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_irq_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_basic(src_basic),
        .src_gen_a(src_gen_a), .src_gen_b(src_gen_b), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic set_src(input logic [7:0] b, input logic [31:0] ga, input logic [31:0] gb);
        @(negedge clk);
        src_basic = b; src_gen_a = ga; src_gen_b = gb;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R1 summary", 6'h00, 32'h0);
        rd_check("R1 pend A",  6'h04, 32'h0);
        rd_check("R1 pend B",  6'h08, 32'h0);
        rd_check("R1 fiq ctl", 6'h0C, 32'h0);
        rd_check("R1 en A",    6'h10, 32'h0);
        rd_check("R1 en B",    6'h14, 32'h0);
        rd_check("R1 en 0",    6'h18, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 fiq", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_masks();
        wr(6'h10, 32'h0000_00F0);
        wr(6'h10, 32'h0000_0F00);
        rd_check("R2 set accumulates", 6'h10, 32'h0000_0FF0);
        wr(6'h1C, 32'h0000_0030);
        rd_check("R3 clear selective", 6'h1C, 32'h0000_0FC0);
        rd_check("R3 readback at set", 6'h10, 32'h0000_0FC0);
        rd_check("R2 other group untouched", 6'h14, 32'h0);
    endtask

    task automatic t_group_a();
        set_src(8'h00, 32'hFFFF_FFFF, 32'h0);
        rd_check("R4 pend A gated", 6'h04, 32'h0000_0FC0);
        wr(6'h04, 32'h0);
        rd_check("R4 pend A read-only", 6'h04, 32'h0000_0FC0);
        // lines 6,8,11 cascade; 7->b10, 9->b11, 10->b12
        rd_check("R6 R7 summary mix", 6'h00, 32'h0000_1D00);
        check("R9 irq high", {31'b0, irq_o}, 32'h1);
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h10, 32'h0004_0000);
        rd_check("R7 shortcut only, no cascade", 6'h00, 32'h0000_2000);
        rd_check("R7 shortcut keeps pend bit", 6'h04, 32'h0004_0000);
        wr(6'h10, 32'h0008_0000);
        rd_check("R7 line19 -> bit14", 6'h00, 32'h0000_6000);
        wr(6'h1C, 32'hFFFF_FFFF);
        set_src(8'h00, 32'h0, 32'h0);
        check("R9 irq low", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_group_b();
        wr(6'h14, 32'h43E0_0001);
        set_src(8'h00, 32'h0, 32'hFFFF_FFFF);
        rd_check("R4 pend B gated", 6'h08, 32'h43E0_0001);
        rd_check("R6 R7 group B summary", 6'h00, 32'h001F_8200);
        wr(6'h24, 32'hFFFF_FFFF);
        rd_check("R6 cascade unmaskable", 6'h00, 32'h001F_8200);
        wr(6'h18, 32'hFFFF_FF00);
        rd_check("R8 upper basic enable inert", 6'h18, 32'h0);
        rd_check("R8 summary unchanged", 6'h00, 32'h001F_8200);
        wr(6'h20, 32'hFFFF_FFFF);
        set_src(8'h00, 32'h0, 32'h0);
    endtask

    task automatic t_basic();
        wr(6'h18, 32'h0000_000F);
        set_src(8'hA5, 32'h0, 32'h0);
        rd_check("R2 basic enable", 6'h18, 32'h0000_000F);
        rd_check("R5 basic pending", 6'h00, 32'h0000_0005);
        check("R9 irq from basic", {31'b0, irq_o}, 32'h1);
        wr(6'h24, 32'h0000_0001);
        rd_check("R3 basic clear", 6'h00, 32'h0000_0004);
        wr(6'h24, 32'hFFFF_FFFF);
        set_src(8'h00, 32'h0, 32'h0);
        check("R9 irq idle", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_fiq();
        wr(6'h0C, 32'hFFFF_FFFF);
        rd_check("R10 ctl readback", 6'h0C, 32'h0000_00FF);
        set_src(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R10 index out of range", {31'b0, fiq_o}, 32'h0);
        wr(6'h0C, 32'h0000_00A3);  // enable, index 35 -> group B line 3
        set_src(8'h00, 32'h0, 32'h0000_0008);
        check("R11 group B line ungated", {31'b0, fiq_o}, 32'h1);
        check("R11 irq unaffected", {31'b0, irq_o}, 32'h0);
        set_src(8'h00, 32'h0, 32'hFFFF_FFF7);
        check("R11 line low", {31'b0, fiq_o}, 32'h0);
        wr(6'h0C, 32'h0000_00C2);  // index 66 -> basic line 2
        set_src(8'h04, 32'h0, 32'h0);
        check("R10 basic index", {31'b0, fiq_o}, 32'h1);
        wr(6'h0C, 32'h0000_0085);  // index 5 -> group A line 5
        set_src(8'hFF, 32'h0000_0020, 32'h0);
        check("R10 group A index", {31'b0, fiq_o}, 32'h1);
        wr(6'h0C, 32'h0000_0005);
        check("R11 enable off", {31'b0, fiq_o}, 32'h0);
        set_src(8'h00, 32'h0, 32'h0);
    endtask

    task automatic t_unmapped();
        rd_check("R12 offset 0x28", 6'h28, 32'h0);
        rd_check("R12 offset 0x3C", 6'h3C, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
        src_basic = '0; src_gen_a = '0; src_gen_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_masks();
        t_group_a();
        t_group_b();
        t_basic();
        t_fiq();
        t_unmapped();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule